// File: doc/BRIEF.md
# Auxiliary Reference Clock Output with Lock Indicator

This block drives one auxiliary output pin. The pin can carry one of three things. It can carry the master clock divided by a programmable integer ratio. It can carry a buffered copy of the oscillator input clock. Or it can carry an active-low flag that shows whether the on-chip PLL has locked. A 6-bit ratio and a mode bit choose between these. A board uses the pin either as a slower reference clock for nearby parts or, behind an external RC filter, as a lock status line.

The divider runs in the master clock domain. The ratio is registered once. Any change to it restarts the divide counter, so the new ratio takes effect from a clean, full output period. Each divided period starts with its high phase. For odd ratios the high phase is one master cycle longer than the low phase. A ratio of 0 or 1 parks the divider and routes the oscillator clock to the pin. The lock mode bit overrides both clock behaviours.

Top module: `aux_refclk_gen`

## Requirements
- R1: While reset is asserted and the ratio is 0 and lock mode is off, the pin equals the oscillator input clock.
- R2: With lock mode off and a steady ratio R in 2..63, the pin is periodic with a period of exactly R master clock cycles.
- R3: In each divided period the pin is high for the first ceil(R/2) master cycles and low for the remaining floor(R/2). This gives R/2 and R/2 for even R, and (R+1)/2 and (R-1)/2 for odd R.
- R4: With lock mode off and ratio 0, the pin equals the oscillator input clock from the second master clock edge after the ratio is applied.
- R5: Ratio 1 is treated as ratio 0. The pin follows the oscillator input clock, and the divider stays parked with its output low.
- R6: With the lock mode bit at 1, the pin equals the inverse of the PLL-locked input, so low means locked. This holds for any ratio.
- R7: Returning the lock mode bit to 0 gives the clock behaviour of R2 to R5 back on the pin.
- R8: A ratio change seen at a master clock edge restarts the counter at that edge. The pin is then high in the cycle that follows, and the new period and duty apply from there. This holds even in the middle of an old period.
- R9: A rising edge of the divided output occurs only at the start of a period, when the divide counter is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; the divider runs on its rising edge |
| osc_clk | input | 1 | Oscillator input clock, passed through for ratio 0 or 1 |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio | input | 6 | Divide ratio R; 0 and 1 select passthrough |
| lock_mode | input | 1 | 1: pin shows the PLL lock status; 0: pin shows a clock |
| pll_locked | input | 1 | High when the PLL is locked |
| aux_out | output | 1 | Auxiliary clock or active-low lock flag |

## Verification
The bench sweeps every valid ratio from 2 to 63 and predicts each output cycle arithmetically from the period and the ceiling-half duty. An off-by-one terminal count would stretch or shrink every period. A floor instead of a ceiling would give odd ratios the wrong duty. The bench changes the ratio in the middle of a period and expects an immediate high phase at the new length. A design that waited for the old period to finish, or that failed to restart the counter, would show a stale phase there. It also drives ratios 0 and 1, where a design that divided by one would toggle instead of following the oscillator. Finally it toggles the lock input under lock mode, where a wrong polarity or a clock leaking through would be caught.

// File: rtl/aux_refclk_pkg.sv
package aux_refclk_pkg;

  localparam int AUX_RW = 6;

  typedef logic [AUX_RW-1:0] ratio_t;

  localparam ratio_t RATIO_ONE  = ratio_t'(1);
  localparam ratio_t RATIO_ZERO = ratio_t'(0);

  // Ratios below two select the oscillator passthrough.
  function automatic logic ratio_is_bypass(input ratio_t r);
    return (r < ratio_t'(2));
  endfunction

  // Length of the high phase: ceiling of r/2.
  function automatic ratio_t high_len(input ratio_t r);
    return (r >> 1) + {{(AUX_RW-1){1'b0}}, r[0]};
  endfunction

  // Terminal count value of the divide counter.
  function automatic ratio_t last_count(input ratio_t r);
    return r - RATIO_ONE;
  endfunction

endpackage

// File: rtl/aux_ratio_track.sv
module aux_ratio_track
  import aux_refclk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ratio_t ratio_in,
  output ratio_t ratio_q,
  output logic   restart,
  output logic   bypass_q
);

  ratio_t held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= RATIO_ZERO;
    end else begin
      held_q <= ratio_in;
    end
  end

  assign ratio_q  = held_q;
  assign restart  = (ratio_in != held_q);
  assign bypass_q = ratio_is_bypass(held_q);

endmodule

// File: rtl/aux_divider.sv
module aux_divider
  import aux_refclk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ratio_t ratio_in,
  input  ratio_t ratio_q,
  input  logic   restart,
  input  logic   bypass_q,
  output ratio_t cnt_o,
  output logic   wrap_o,
  output logic   div_o
);

  ratio_t cnt_q;
  ratio_t cnt_nxt;
  logic   div_q;
  logic   div_nxt;
  logic   at_end;

  assign at_end = !bypass_q && (cnt_q == last_count(ratio_q));

  always_comb begin
    if (restart || bypass_q || at_end) begin
      cnt_nxt = RATIO_ZERO;
    end else begin
      cnt_nxt = cnt_q + RATIO_ONE;
    end
  end

  // The ratio register loads ratio_in on every edge, so ratio_in is the
  // ratio in force after the edge whether or not a restart happens.
  assign div_nxt = !ratio_is_bypass(ratio_in) && (cnt_nxt < high_len(ratio_in));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RATIO_ZERO;
      div_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      div_q <= div_nxt;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = at_end;
  assign div_o  = div_q;

endmodule

// File: rtl/aux_pin_sel.sv
module aux_pin_sel #(
  parameter bit LOCK_ACTIVE_LOW = 1'b1
) (
  input  logic lock_mode,
  input  logic pll_locked,
  input  logic bypass_q,
  input  logic osc_clk,
  input  logic div_clk,
  output logic pin
);

  logic lock_level;
  logic clk_level;

  generate
    if (LOCK_ACTIVE_LOW) begin : g_lock_low
      assign lock_level = !pll_locked;
    end else begin : g_lock_high
      assign lock_level = pll_locked;
    end
  endgenerate

  assign clk_level = bypass_q ? osc_clk : div_clk;
  assign pin       = lock_mode ? lock_level : clk_level;

endmodule

// File: rtl/aux_refclk_gen.sv
module aux_refclk_gen
  import aux_refclk_pkg::*;
#(
  parameter bit LOCK_ACTIVE_LOW = 1'b1
) (
  input  logic              mclk,
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic [AUX_RW-1:0] ratio,
  input  logic              lock_mode,
  input  logic              pll_locked,
  output logic              aux_out
);

  ratio_t ratio_q;
  logic   restart;
  logic   bypass_q;
  ratio_t div_cnt;
  logic   div_wrap;
  logic   div_clk;

  aux_ratio_track u_track (
    .clk      (mclk),
    .rst_n    (rst_n),
    .ratio_in (ratio),
    .ratio_q  (ratio_q),
    .restart  (restart),
    .bypass_q (bypass_q)
  );

  aux_divider u_div (
    .clk      (mclk),
    .rst_n    (rst_n),
    .ratio_in (ratio),
    .ratio_q  (ratio_q),
    .restart  (restart),
    .bypass_q (bypass_q),
    .cnt_o    (div_cnt),
    .wrap_o   (div_wrap),
    .div_o    (div_clk)
  );

  aux_pin_sel #(.LOCK_ACTIVE_LOW(LOCK_ACTIVE_LOW)) u_sel (
    .lock_mode  (lock_mode),
    .pll_locked (pll_locked),
    .bypass_q   (bypass_q),
    .osc_clk    (osc_clk),
    .div_clk    (div_clk),
    .pin        (aux_out)
  );

endmodule

// File: rtl/aux_refclk_chk.sv
module aux_refclk_chk
  import aux_refclk_pkg::*;
(
  input logic   mclk,
  input logic   rst_n,
  input logic   osc_clk,
  input ratio_t ratio,
  input logic   lock_mode,
  input logic   pll_locked,
  input logic   aux_out,
  input ratio_t ratio_q,
  input logic   restart,
  input logic   bypass_q,
  input ratio_t div_cnt,
  input logic   div_wrap,
  input logic   div_clk
);

  // R8: a restart into a dividing ratio opens a fresh high phase
  p_restart_high_r8: assert property (@(posedge mclk) disable iff (!rst_n)
    (restart && !ratio_is_bypass(ratio)) |=> (div_clk && div_cnt == RATIO_ZERO));

  // R2: the counter stays inside one period
  p_cnt_bound_r2: assert property (@(posedge mclk) disable iff (!rst_n)
    !bypass_q |-> (div_cnt <= last_count(ratio_q)));

  // R2: terminal count wraps to zero
  p_wrap_zero_r2: assert property (@(posedge mclk) disable iff (!rst_n)
    (div_wrap && !restart) |=> (div_cnt == RATIO_ZERO && div_clk));

  // R9: rising edges only at a period start
  p_rise_start_r9: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(div_clk) |-> (div_cnt == RATIO_ZERO));

  // R3: the high phase ends after ceil(R/2) cycles
  p_fall_half_r3: assert property (@(posedge mclk) disable iff (!rst_n)
    ($fell(div_clk) && !bypass_q) |-> (div_cnt == high_len(ratio_q)));

  // R5: divider parked low during passthrough
  p_parked_r5: assert property (@(posedge mclk) disable iff (!rst_n)
    bypass_q |-> !div_clk);

  // R6: lock flag is active low
  p_lock_low_r6: assert property (@(posedge mclk) disable iff (!rst_n)
    lock_mode |-> (aux_out == !pll_locked));

  // R4: passthrough follows the oscillator
  p_osc_pass_r4: assert property (@(posedge mclk) disable iff (!rst_n)
    (!lock_mode && bypass_q) |-> (aux_out == osc_clk));

endmodule

bind aux_refclk_gen aux_refclk_chk u_chk (
  .mclk       (mclk),
  .rst_n      (rst_n),
  .osc_clk    (osc_clk),
  .ratio      (ratio),
  .lock_mode  (lock_mode),
  .pll_locked (pll_locked),
  .aux_out    (aux_out),
  .ratio_q    (ratio_q),
  .restart    (restart),
  .bypass_q   (bypass_q),
  .div_cnt    (div_cnt),
  .div_wrap   (div_wrap),
  .div_clk    (div_clk)
);

// File: tb/test_aux_refclk_gen.sv
`timescale 1ns/100ps
module test_aux_refclk_gen;

  logic       mclk = 1'b0;
  logic       osc_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] ratio = 6'd0;
  logic       lock_mode = 1'b0;
  logic       pll_locked = 1'b0;
  logic       aux_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  aux_refclk_gen i_aux_refclk_gen (
    .mclk       (mclk),
    .osc_clk    (osc_clk),
    .rst_n      (rst_n),
    .ratio      (ratio),
    .lock_mode  (lock_mode),
    .pll_locked (pll_locked),
    .aux_out    (aux_out)
  );

  always #5 mclk = ~mclk;

  // Oscillator edges land on half-nanosecond times, never on a sample.
  initial begin
    #3.5;
    forever #7 osc_clk = ~osc_clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_high(input int r);
    if (r % 2 == 0) return r / 2;
    return r / 2 + 1;
  endfunction

  // Apply ratio at a falling edge, then predict every following cycle.
  task automatic run_ratio(input int r, input int n, input string req);
    ratio = 6'(r);
    @(posedge mclk);
    for (int k = 0; k < n; k++) begin
      @(negedge mclk);
      check(aux_out == ((k % r) < exp_high(r)), req, int'(aux_out),
            int'((k % r) < exp_high(r)));
    end
  endtask

  task automatic check_pass(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge mclk);
      #2;
      check(aux_out == osc_clk, req, int'(aux_out), int'(osc_clk));
    end
  endtask

  initial begin
    // R1: reset state shows the oscillator
    check_pass(6, "R1");
    @(negedge mclk);
    rst_n = 1'b1;
    check_pass(6, "R4");

    // R2 and R3: full sweep of valid ratios
    for (int r = 2; r <= 63; r++) begin
      run_ratio(r, 3 * r, (r % 2 == 0) ? "R2/R3 even" : "R2/R3 odd");
    end

    // R8: change in the middle of a period
    run_ratio(9, 4, "R8 lead");
    run_ratio(6, 18, "R8");
    run_ratio(63, 40, "R8 lead");
    run_ratio(2, 10, "R8");

    // R5: ratio 1 passes the oscillator
    ratio = 6'd1;
    @(negedge mclk);
    check_pass(20, "R5");

    // R9: from passthrough into division the first cycle is high
    run_ratio(5, 15, "R9");

    // R4: ratio 0 again
    ratio = 6'd0;
    @(negedge mclk);
    check_pass(20, "R4");

    // R6: lock flag active low, any ratio
    lock_mode = 1'b1;
    ratio = 6'd7;
    for (int k = 0; k < 24; k++) begin
      @(negedge mclk);
      pll_locked = k[1] ^ k[3];
      if (k == 12) ratio = 6'd0;
      #1;
      check(aux_out == !pll_locked, "R6", int'(aux_out), int'(!pll_locked));
    end

    // R7: clock behaviour returns
    @(negedge mclk);
    lock_mode = 1'b0;
    run_ratio(11, 33, "R7");
    ratio = 6'd1;
    @(negedge mclk);
    check_pass(8, "R7");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule